// File: doc/BRIEF.md
# Single-Cycle Integer ALU Execution Path

This block executes one three-operand integer instruction per clock cycle for a 32-bit load/store processor. A 32-bit instruction word enters each cycle. The block splits it into its fields and reads two source registers from a 32-by-32-bit register file. It then applies one of six arithmetic or logic operations and writes the result back at the next rising clock edge.

Two instruction shapes are accepted. The three-register shape has opcode zero, and a function code picks the operation. The constant shape replaces the second source register with a signed 16-bit constant, sign-extended to 32 bits. In that shape the destination number is taken from the field that otherwise names the second source. The result, a write-commit strobe and the destination number are visible at the ports. Register contents are observed by running an instruction that reads them.

Top module: `alu_exec_path`

## Requirements
- R1: After reset every register reads as zero, and `wb_fire` is low while `wr_en` is low.
- R2: Opcode 0x00 with function 0x20 writes rs + rt into the rd register, wrapping modulo 2^32 with no overflow indication.
- R3: Opcode 0x00 with function 0x22 writes rs - rt into rd, wrapping modulo 2^32.
- R4: Opcode 0x00 with function 0x24 writes the bitwise AND of rs and rt into rd, and function 0x25 writes the bitwise OR.
- R5: Opcode 0x00 with function 0x2A writes 1 into rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R6: Opcode 0x08 writes rs plus the sign-extended bits [15:0] into the register named by bits [20:16].
- R7: Fields sit at op [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0]. A three-register instruction reports rd on `wb_addr`, and a constant instruction reports rt.
- R8: Register 0 always reads as zero, and a write aimed at it leaves it zero.
- R9: Any opcode or function code outside R2 to R6 holds `wb_fire` low and changes no register.
- R10: With `wr_en` low, `wb_fire` stays low and no register changes, although `alu_result` is still computed.
- R11: A write lands on the rising edge. An instruction that reads its own destination register sees the old value in that cycle, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| instr | input | 32 | Instruction word for this cycle |
| wr_en | input | 1 | Allows the result to be written back |
| alu_result | output | 32 | Combinational ALU output for the current instruction |
| wb_fire | output | 1 | High when this cycle's result is written at the next edge |
| wb_addr | output | 5 | Destination register number of the current instruction |

## Verification
The hardest situation to reach from the ports is an instruction that reads and writes the same register in one cycle. The bench must show two things: the old value feeds the ALU before the edge, and the new value appears only after it. The bench holds such an instruction across a clock edge and samples `alu_result` just before the edge. It then reads the register back with a separate OR-with-zero instruction.

Writes that must have no effect are checked the same way, by reading the targeted register afterwards. These cover writes to register 0, writes from illegal encodings and writes with `wr_en` low.

// File: rtl/alu_exec_path.sv
module alu_exec_path #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic            wr_en,
  output logic [XLEN-1:0] alu_result,
  output logic            wb_fire,
  output logic [4:0]      wb_addr
);
  localparam int RW = 5;
  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;

  typedef enum logic [2:0] {K_ADD, K_SUB, K_AND, K_OR, K_SLT, K_BAD} kind_t;

  logic [5:0]    opc, fn;
  logic [RW-1:0] src_a, src_b, dst_r;
  logic [15:0]   konst;
  logic          use_k;
  kind_t         kind;

  assign opc   = instr[31:26];
  assign src_a = instr[25:21];
  assign src_b = instr[20:16];
  assign dst_r = instr[15:11];
  assign fn    = instr[5:0];
  assign konst = instr[15:0];
  assign use_k = (opc == OPC_ADDI);

  always_comb begin
    kind = K_BAD;
    if (use_k) kind = K_ADD;
    else if (opc == OPC_REG) begin
      case (fn)
        6'h20:   kind = K_ADD;
        6'h22:   kind = K_SUB;
        6'h24:   kind = K_AND;
        6'h25:   kind = K_OR;
        6'h2A:   kind = K_SLT;
        default: kind = K_BAD;
      endcase
    end
  end

  logic [XLEN-1:0] regs [NREGS];
  logic [XLEN-1:0] va, vb, opnd2;

  assign va    = (src_a == '0) ? '0 : regs[src_a];
  assign vb    = (src_b == '0) ? '0 : regs[src_b];
  assign opnd2 = use_k ? {{(XLEN-16){konst[15]}}, konst} : vb;

  always_comb begin
    case (kind)
      K_ADD:   alu_result = va + opnd2;
      K_SUB:   alu_result = va - opnd2;
      K_AND:   alu_result = va & opnd2;
      K_OR:    alu_result = va | opnd2;
      K_SLT:   alu_result = {{(XLEN-1){1'b0}}, ($signed(va) < $signed(opnd2))};
      default: alu_result = '0;
    endcase
  end

  assign wb_addr = use_k ? src_b : dst_r;
  assign wb_fire = wr_en && (kind != K_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wb_fire && wb_addr != '0) begin
      regs[wb_addr] <= alu_result;
    end
  end
endmodule

module alu_exec_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr,
  input logic        wr_en,
  input logic [31:0] alu_result,
  input logic        wb_fire,
  input logic [4:0]  wb_addr
);
  logic warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 1'b0; else warm <= 1'b1;

  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wb_fire);

  assert_bad_fn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h00 && instr[5:0] == 6'h21) |-> !wb_fire);

  assert_slt_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h00 && instr[5:0] == 6'h2A) |-> alu_result[31:1] == '0);

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h00 && instr[5:0] == 6'h25 && instr[25:16] == '0)
      |-> alu_result == '0);

  assert_imm_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:26] == 6'h08) |-> wb_addr == instr[20:16]);

  assert_write_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(wb_fire) && $past(wb_addr) != '0 &&
     instr[31:26] == 6'h00 && instr[5:0] == 6'h25 &&
     instr[25:21] == $past(wb_addr) && instr[20:16] == '0)
      |-> alu_result == $past(alu_result));
endmodule

bind alu_exec_path alu_exec_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .wr_en(wr_en),
  .alu_result(alu_result), .wb_fire(wb_fire), .wb_addr(wb_addr)
);

// File: tb/tb_alu_exec_path.sv
module tb_alu_exec_path;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] instr = '0;
  logic        wr_en = 0;
  logic [31:0] alu_result;
  logic        wb_fire;
  logic [4:0]  wb_addr;
  int n_run = 0, n_bad = 0;

  always #10 clk = ~clk;

  alu_exec_path dut (.clk(clk), .rst_n(rst_n), .instr(instr), .wr_en(wr_en),
    .alu_result(alu_result), .wb_fire(wb_fire), .wb_addr(wb_addr));

  function automatic logic [31:0] rfmt(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] ifmt(input logic [5:0] op, input int rs, rt, input logic [15:0] k);
    return {op, rs[4:0], rt[4:0], k};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic we, input string req,
                      input logic [31:0] res, input logic fire, input logic [4:0] addr);
    @(negedge clk);
    instr = ins; wr_en = we;
    #2;
    chk(req, alu_result, res);
    chk(req, {31'd0, wb_fire}, {31'd0, fire});
    if (fire) chk(req, {27'd0, wb_addr}, {27'd0, addr});
    @(posedge clk);
  endtask

  task automatic peek(input int r, input logic [31:0] exp, input string req);
    step(rfmt(r, 0, 0, 6'h25), 1'b0, req, exp, 1'b0, 5'd0);
  endtask

  task automatic t_reset;
    peek(5, 32'd0, "R1");
    peek(31, 32'd0, "R1");
  endtask

  task automatic t_imm;
    step(ifmt(6'h08, 0, 1, 16'd100), 1, "R6", 32'd100, 1, 5'd1);
    step(ifmt(6'h08, 0, 2, 16'hFFFD), 1, "R6", 32'hFFFFFFFD, 1, 5'd2);
    peek(1, 32'd100, "R6");
    peek(2, 32'hFFFFFFFD, "R6");
  endtask

  task automatic t_arith;
    step(rfmt(1, 2, 3, 6'h20), 1, "R2_R7", 32'd97, 1, 5'd3);
    peek(3, 32'd97, "R2");
    step(rfmt(0, 1, 6, 6'h22), 1, "R3", 32'hFFFFFF9C, 1, 5'd6);
    peek(6, 32'hFFFFFF9C, "R3");
    step(rfmt(1, 2, 8, 6'h24), 1, "R4", 32'd100, 1, 5'd8);
    step(rfmt(1, 6, 9, 6'h25), 1, "R4", 32'hFFFFFFFC, 1, 5'd9);
    peek(9, 32'hFFFFFFFC, "R4");
  endtask

  task automatic t_slt;
    step(rfmt(2, 1, 10, 6'h2A), 1, "R5", 32'd1, 1, 5'd10);
    step(rfmt(1, 2, 11, 6'h2A), 1, "R5", 32'd0, 1, 5'd11);
    peek(10, 32'd1, "R5");
  endtask

  task automatic t_zero;
    step(ifmt(6'h08, 0, 0, 16'd55), 1, "R8", 32'd55, 1, 5'd0);
    peek(0, 32'd0, "R8");
  endtask

  task automatic t_illegal;
    step(rfmt(2, 2, 1, 6'h21), 1, "R9", 32'd0, 0, 5'd0);
    step(ifmt(6'h23, 0, 1, 16'd9), 1, "R9", 32'd0, 0, 5'd0);
    peek(1, 32'd100, "R9");
  endtask

  task automatic t_nowrite;
    step(ifmt(6'h08, 0, 1, 16'd7), 0, "R10", 32'd7, 0, 5'd0);
    peek(1, 32'd100, "R10");
  endtask

  task automatic t_same_cycle;
    step(ifmt(6'h08, 1, 1, 16'd1), 1, "R11", 32'd101, 1, 5'd1);
    peek(1, 32'd101, "R11");
  endtask

  initial begin
    #15 rst_n = 1;
    t_reset();
    t_imm();
    t_arith();
    t_slt();
    t_zero();
    t_illegal();
    t_nowrite();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule